// File: doc/BRIEF.md
# Received PAUSE Decoder and Transmit Hold

This block sits on the receive byte stream of a full-duplex Ethernet MAC. It recognizes MAC control PAUSE frames and extracts their 16-bit pause quanta. It then asks the local transmitter to stop for that many slot times, where one slot time is 512 bit times on the media-independent interface. The receive path supplies one byte per cycle with start and end markers. Frame-check-sequence checking happens upstream, and that logic reports the result with a good flag on the last byte. The block also takes the station's own unicast address, two enable bits and a slot tick that pulses once per slot time.

A four-state parser (`PS_IDLE`, `PS_HEADER`, `PS_TRAILER`, `PS_DISCARD`) walks the header. A start byte always enters `PS_HEADER`, or enters `PS_DISCARD` if that first byte already mismatches. From `PS_HEADER` the parser moves to `PS_DISCARD` on any mismatching address, type or opcode byte. It moves to `PS_TRAILER` after the last quanta byte, and back to `PS_IDLE` when the frame ends early. `PS_TRAILER` and `PS_DISCARD` both return to `PS_IDLE` on the end byte, and only `PS_TRAILER` with a good flag produces an accept. A down-counter is loaded with the accepted quanta and decrements on each slot tick. A two-state gate (`GS_OPEN`, `GS_HELD`) moves `GS_OPEN` to `GS_HELD` only while the transmitter is idle between frames. It moves `GS_HELD` to `GS_OPEN` once the counter is empty or flow control is turned off.

Top module: `pause_rx_hold`

## Requirements
- R1: After reset, and while reset is applied even in the middle of a hold, `tx_inhibit` is low and the hold counter is empty.
- R2: A frame is accepted when its bytes 0..5 equal a permitted destination (byte 0 is the most significant byte of the 48-bit address), bytes 12..13 are 0x88 then 0x08, bytes 14..15 are 0x00 then 0x01, it is at least 19 bytes long, and `rx_good` is high with its end byte. Its quanta is byte 16 (high) followed by byte 17 (low).
- R3: A frame with a wrong type byte, a wrong opcode byte, `rx_good` low, or a length of 18 bytes or fewer changes nothing at the output.
- R4: The destination 01-80-C2-00-00-01 is always permitted. `station_addr` is permitted only while `ucast_en` is high. Any other destination is ignored.
- R5: While `rx_fc_en` is low no frame affects `tx_inhibit`, and clearing `rx_fc_en` during a hold drops `tx_inhibit` on the next clock and empties the counter.
- R6: For an accepted nonzero quanta N, `tx_inhibit` is high at the second clock after the end byte is taken. It stays high through N−1 slot ticks and falls one clock after the edge that takes the N-th tick.
- R7: A PAUSE frame accepted during a hold replaces the remaining count with its own quanta.
- R8: An accepted quanta of zero empties the counter on the clock after acceptance, so a running hold ends one clock later.
- R9: `tx_inhibit` rises only on a clock at which `tx_busy` was low. A pending hold waits while `tx_busy` is high.
- R10: When an acceptance and a slot tick arrive at the same clock, the new quanta is loaded and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_sof | input | 1 | The present byte is the first of a frame |
| rx_eof | input | 1 | The present byte is the last of a frame |
| rx_good | input | 1 | Frame passed its check; read with the last byte |
| rx_data | input | 8 | Received byte |
| station_addr | input | 48 | Station unicast address, first transmitted byte in bits 47:40 |
| ucast_en | input | 1 | Also accept PAUSE frames sent to `station_addr` |
| rx_fc_en | input | 1 | Receive flow control enable |
| slot_tick | input | 1 | One pulse per slot time |
| tx_busy | input | 1 | Local transmitter is in the middle of a frame |
| tx_inhibit | output | 1 | Transmitter must not start a new frame |

## Verification
The counter load and the counter decrement can fall in the same clock. The bench provokes this by raising `slot_tick` for exactly the clock at which a second PAUSE frame is accepted on top of a long running hold. It then counts the ticks the new hold lasts: a dropped load or a counted tick both show up as a wrong hold length. Gate entry and gate release can also contend, when a hold is pending while `tx_busy` is high. The bench judges that case by watching `tx_inhibit` stay low until the clock after `tx_busy` falls.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;

    // Width of the pause quanta field and of the hold counter.
    localparam int QW       = 16;
    // Header layout of a MAC control frame, in byte positions.
    localparam int DA_LEN   = 6;
    localparam int TYPE_OFS = 12;
    localparam int OPC_OFS  = 14;
    localparam int QNT_OFS  = 16;
    localparam int HDR_LEN  = QNT_OFS + 2;
    localparam int IDX_W    = $clog2(HDR_LEN + 1);

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_HEADER,
        PS_TRAILER,
        PS_DISCARD
    } parse_st_t;

    typedef enum logic {
        GS_OPEN,
        GS_HELD
    } gate_st_t;

endpackage

// File: rtl/pause_rx_parse.sv
module pause_rx_parse
    import pause_rx_pkg::*;
#(
    parameter logic [47:0] MC_ADDR   = 48'h0180_C200_0001,
    parameter logic [15:0] CTRL_TYPE = 16'h8808,
    parameter logic [15:0] PAUSE_OPC = 16'h0001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic          rx_good,
    input  logic [7:0]    rx_data,
    input  logic [47:0]   station_addr,
    input  logic          ucast_en,
    output logic          acc_valid,
    output logic [QW-1:0] acc_quanta
);

    parse_st_t        st, st_nxt;
    logic [IDX_W-1:0] idx;
    logic             mc_ok, uc_ok;
    logic [7:0]       q_hi;
    logic [QW-1:0]    q_val;

    logic [7:0] mc_byte [DA_LEN];
    logic [7:0] uc_byte [DA_LEN];

    // Split both candidate addresses into bytes, first on the wire first.
    for (genvar g = 0; g < DA_LEN; g++) begin : g_addr
        assign mc_byte[g] = MC_ADDR[47-8*g -: 8];
        assign uc_byte[g] = station_addr[47-8*g -: 8];
    end

    logic             start, step;
    logic [IDX_W-1:0] pos;
    logic             in_da;
    logic [2:0]       da_i;
    logic             mc_hit, uc_hit, fld_bad, drop_now, acc_fire;

    // Byte classification.
    always_comb begin
        start   = rx_valid && rx_sof;
        step    = rx_valid && !rx_sof;
        pos     = start ? '0 : idx;
        in_da   = (int'(pos) < DA_LEN);
        da_i    = in_da ? pos[2:0] : 3'd0;
        mc_hit  = in_da && (rx_data == mc_byte[da_i]) && ((pos == '0) || mc_ok);
        uc_hit  = in_da && ucast_en && (rx_data == uc_byte[da_i]) && ((pos == '0) || uc_ok);
        fld_bad = 1'b0;
        unique case (int'(pos))
            TYPE_OFS:     fld_bad = (rx_data != CTRL_TYPE[15:8]);
            TYPE_OFS + 1: fld_bad = (rx_data != CTRL_TYPE[7:0]);
            OPC_OFS:      fld_bad = (rx_data != PAUSE_OPC[15:8]);
            OPC_OFS + 1:  fld_bad = (rx_data != PAUSE_OPC[7:0]);
            default:      fld_bad = 1'b0;
        endcase
        drop_now = (in_da && !mc_hit && !uc_hit) || fld_bad;
    end

    // Next-state logic.
    always_comb begin
        st_nxt = st;
        if (start) begin
            if (rx_eof)        st_nxt = PS_IDLE;
            else if (drop_now) st_nxt = PS_DISCARD;
            else               st_nxt = PS_HEADER;
        end else if (step) begin
            unique case (st)
                PS_IDLE: st_nxt = PS_IDLE;
                PS_HEADER: begin
                    if (rx_eof)                             st_nxt = PS_IDLE;
                    else if (drop_now)                      st_nxt = PS_DISCARD;
                    else if (int'(idx) == HDR_LEN - 1)      st_nxt = PS_TRAILER;
                    else                                    st_nxt = PS_HEADER;
                end
                PS_TRAILER: st_nxt = rx_eof ? PS_IDLE : PS_TRAILER;
                PS_DISCARD: st_nxt = rx_eof ? PS_IDLE : PS_DISCARD;
                default:    st_nxt = PS_IDLE;
            endcase
        end
    end

    // Output decode: acceptance on the good end byte of a complete header.
    always_comb begin
        acc_fire = step && rx_eof && rx_good && (st == PS_TRAILER);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PS_IDLE;
        else        st <= st_nxt;
    end

    // Header bookkeeping and registered acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx        <= '0;
            mc_ok      <= 1'b0;
            uc_ok      <= 1'b0;
            q_hi       <= '0;
            q_val      <= '0;
            acc_valid  <= 1'b0;
            acc_quanta <= '0;
        end else begin
            if (start) begin
                idx   <= IDX_W'(1);
                mc_ok <= mc_hit;
                uc_ok <= uc_hit;
            end else if (step && (st == PS_HEADER)) begin
                idx <= idx + IDX_W'(1);
                if (in_da) begin
                    mc_ok <= mc_hit;
                    uc_ok <= uc_hit;
                end
                if (int'(pos) == QNT_OFS)     q_hi  <= rx_data;
                if (int'(pos) == QNT_OFS + 1) q_val <= {q_hi, rx_data};
            end
            acc_valid <= acc_fire;
            if (acc_fire) acc_quanta <= q_val;
        end
    end

endmodule

// File: rtl/pause_hold_timer.sv
module pause_hold_timer
    import pause_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          tick,
    output logic [QW-1:0] cnt,
    output logic          pending
);

    // Load takes priority over a coincident tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!enable)            cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (tick && cnt != '0)  cnt <= cnt - QW'(1);
    end

    always_comb pending = (cnt != '0);

endmodule

// File: rtl/pause_tx_gate.sv
module pause_tx_gate
    import pause_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pending,
    input  logic tx_busy,
    output logic inhibit
);

    gate_st_t st, st_nxt;

    always_comb begin
        st_nxt = st;
        unique case (st)
            GS_OPEN: if (enable && pending && !tx_busy) st_nxt = GS_HELD;
            GS_HELD: if (!enable || !pending)           st_nxt = GS_OPEN;
            default: st_nxt = GS_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= GS_OPEN;
        else        st <= st_nxt;
    end

    always_comb inhibit = (st == GS_HELD);

endmodule

// File: rtl/pause_rx_hold.sv
module pause_rx_hold
    import pause_rx_pkg::*;
#(
    parameter logic [47:0] MC_ADDR   = 48'h0180_C200_0001,
    parameter logic [15:0] CTRL_TYPE = 16'h8808,
    parameter logic [15:0] PAUSE_OPC = 16'h0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_good,
    input  logic [7:0]  rx_data,
    input  logic [47:0] station_addr,
    input  logic        ucast_en,
    input  logic        rx_fc_en,
    input  logic        slot_tick,
    input  logic        tx_busy,
    output logic        tx_inhibit
);

    logic          acc_valid;
    logic [QW-1:0] acc_quanta;
    logic [QW-1:0] hold_cnt;
    logic          hold_pending;

    pause_rx_parse #(
        .MC_ADDR   (MC_ADDR),
        .CTRL_TYPE (CTRL_TYPE),
        .PAUSE_OPC (PAUSE_OPC)
    ) u_parse (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_good      (rx_good),
        .rx_data      (rx_data),
        .station_addr (station_addr),
        .ucast_en     (ucast_en),
        .acc_valid    (acc_valid),
        .acc_quanta   (acc_quanta)
    );

    pause_hold_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (rx_fc_en),
        .load     (acc_valid),
        .load_val (acc_quanta),
        .tick     (slot_tick),
        .cnt      (hold_cnt),
        .pending  (hold_pending)
    );

    pause_tx_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (rx_fc_en),
        .pending (hold_pending),
        .tx_busy (tx_busy),
        .inhibit (tx_inhibit)
    );

endmodule

// File: rtl/pause_rx_hold_chk.sv
module pause_rx_hold_chk
    import pause_rx_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          rx_fc_en,
    input logic          tx_busy,
    input logic          slot_tick,
    input logic          acc_valid,
    input logic [QW-1:0] acc_quanta,
    input logic [QW-1:0] hold_cnt,
    input logic          tx_inhibit
);

    // R5
    fc_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_fc_en |=> (!tx_inhibit && hold_cnt == '0));

    // R9
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_inhibit) |-> $past(!tx_busy));

    // R7
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && rx_fc_en) |=> (hold_cnt == $past(acc_quanta)));

    // R8
    zero_quanta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_quanta == '0) |=> (hold_cnt == '0));

    // R6
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fc_en && slot_tick && !acc_valid && hold_cnt != '0)
        |=> (hold_cnt == $past(hold_cnt) - QW'(1)));

    // R6
    empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_inhibit && hold_cnt == '0) |=> !tx_inhibit);

    // R2
    accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !acc_valid);

endmodule

bind pause_rx_hold pause_rx_hold_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_fc_en   (rx_fc_en),
    .tx_busy    (tx_busy),
    .slot_tick  (slot_tick),
    .acc_valid  (acc_valid),
    .acc_quanta (acc_quanta),
    .hold_cnt   (hold_cnt),
    .tx_inhibit (tx_inhibit)
);

// File: tb/pause_rx_hold_bench.sv
`timescale 1ns/1ps
module pause_rx_hold_bench;

    localparam logic [47:0] MC  = 48'h0180_C200_0001;
    localparam logic [47:0] STA = 48'h0211_2233_4455;
    localparam logic [47:0] OTH = 48'h0211_2233_4456;
    localparam logic [47:0] SRC = 48'h0ABB_CCDD_EE01;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_sof, rx_eof, rx_good;
    logic [7:0]  rx_data;
    logic [47:0] station_addr;
    logic        ucast_en, rx_fc_en, slot_tick, tx_busy;
    logic        tx_inhibit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pause_rx_hold u_pause_rx_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_good      (rx_good),
        .rx_data      (rx_data),
        .station_addr (station_addr),
        .ucast_en     (ucast_en),
        .rx_fc_en     (rx_fc_en),
        .slot_tick    (slot_tick),
        .tx_busy      (tx_busy),
        .tx_inhibit   (tx_inhibit)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] byte_at(input int p, input logic [47:0] dst,
                                           input logic [15:0] typ, input logic [15:0] opc,
                                           input logic [15:0] q);
        if (p < 6)       return dst[47-8*p -: 8];
        else if (p < 12) return SRC[47-8*(p-6) -: 8];
        else if (p == 12) return typ[15:8];
        else if (p == 13) return typ[7:0];
        else if (p == 14) return opc[15:8];
        else if (p == 15) return opc[7:0];
        else if (p == 16) return q[15:8];
        else if (p == 17) return q[7:0];
        else              return 8'h00;
    endfunction

    // Returns at the falling edge after the end byte was clocked in.
    task automatic send_frame(input logic [47:0] dst, input logic [15:0] typ,
                              input logic [15:0] opc, input logic [15:0] q,
                              input int len, input logic good);
        for (int p = 0; p < len; p++) begin
            rx_valid = 1'b1;
            rx_sof   = (p == 0);
            rx_eof   = (p == len - 1);
            rx_good  = good && (p == len - 1);
            rx_data  = byte_at(p, dst, typ, opc, q);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0; rx_data = 8'h00;
    endtask

    task automatic pause_mc(input logic [15:0] q);
        send_frame(MC, 16'h8808, 16'h0001, q, 64, 1'b1);
    endtask

    task automatic pulse_tick();
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_hold();
        rx_fc_en = 1'b0;
        wait_cyc(2);
        rx_fc_en = 1'b1;
        wait_cyc(1);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0; rx_data = 8'h00;
        station_addr = STA; ucast_en = 1'b0; rx_fc_en = 1'b1; slot_tick = 1'b0; tx_busy = 1'b0;
        wait_cyc(3);
        chk(tx_inhibit, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        wait_cyc(2);
        chk(tx_inhibit, 1'b0, "R1 after reset");

        // R6 / R8: sweep of quanta values, hold length counted in ticks
        for (int q = 0; q <= 6; q++) begin
            pause_mc(16'(q));
            wait_cyc(2);
            chk(tx_inhibit, q != 0, $sformatf("R6 R8 start q=%0d", q));
            for (int i = 1; i <= q; i++) begin
                pulse_tick();
                chk(tx_inhibit, i < q, $sformatf("R6 tick %0d of q=%0d", i, q));
            end
            clear_hold();
        end

        // R2 quanta byte order: 0x0102 must survive 257 ticks
        pause_mc(16'h0102);
        wait_cyc(2);
        for (int i = 0; i < 257; i++) pulse_tick();
        chk(tx_inhibit, 1'b1, "R2 high byte weight after 257 ticks");
        pulse_tick();
        chk(tx_inhibit, 1'b0, "R2 release after 258 ticks");

        // R4 / R5: destination x unicast enable x flow control enable
        for (int dk = 0; dk < 3; dk++) begin
            for (int ue = 0; ue < 2; ue++) begin
                for (int fc = 0; fc < 2; fc++) begin
                    logic [47:0] d;
                    logic        exp;
                    d = (dk == 0) ? MC : (dk == 1) ? STA : OTH;
                    exp = (fc == 1) && ((dk == 0) || (dk == 1 && ue == 1));
                    ucast_en = ue[0];
                    rx_fc_en = fc[0];
                    send_frame(d, 16'h8808, 16'h0001, 16'd3, 64, 1'b1);
                    wait_cyc(2);
                    chk(tx_inhibit, exp, $sformatf("R4 R5 dest=%0d ucast=%0d fc=%0d", dk, ue, fc));
                    clear_hold();
                end
            end
        end
        ucast_en = 1'b0;
        rx_fc_en = 1'b1;

        // R3: malformed or rejected frames
        send_frame(MC, 16'h8809, 16'h0001, 16'd3, 64, 1'b1);
        wait_cyc(2); chk(tx_inhibit, 1'b0, "R3 wrong type low byte");
        send_frame(MC, 16'h0808, 16'h0001, 16'd3, 64, 1'b1);
        wait_cyc(2); chk(tx_inhibit, 1'b0, "R3 wrong type high byte");
        send_frame(MC, 16'h8808, 16'h0002, 16'd3, 64, 1'b1);
        wait_cyc(2); chk(tx_inhibit, 1'b0, "R3 wrong opcode");
        send_frame(MC, 16'h8808, 16'h0101, 16'd3, 64, 1'b1);
        wait_cyc(2); chk(tx_inhibit, 1'b0, "R3 wrong opcode high byte");
        send_frame(MC, 16'h8808, 16'h0001, 16'd3, 64, 1'b0);
        wait_cyc(2); chk(tx_inhibit, 1'b0, "R3 frame not good");
        send_frame(MC, 16'h8808, 16'h0001, 16'd3, 18, 1'b1);
        wait_cyc(2); chk(tx_inhibit, 1'b0, "R3 18-byte frame");
        send_frame(MC, 16'h8808, 16'h0001, 16'd3, 19, 1'b1);
        wait_cyc(2); chk(tx_inhibit, 1'b1, "R2 19-byte frame accepted");
        clear_hold();

        // R5: clearing flow control during a hold
        pause_mc(16'd9);
        wait_cyc(2);
        rx_fc_en = 1'b0;
        wait_cyc(1);
        chk(tx_inhibit, 1'b0, "R5 release on disable");
        rx_fc_en = 1'b1;
        wait_cyc(2);
        chk(tx_inhibit, 1'b0, "R5 counter emptied");

        // R7: reload overwrites the remaining count
        pause_mc(16'd5);
        wait_cyc(2);
        pulse_tick(); pulse_tick();
        pause_mc(16'd2);
        wait_cyc(2);
        pulse_tick();
        chk(tx_inhibit, 1'b1, "R7 one tick after reload");
        pulse_tick();
        chk(tx_inhibit, 1'b0, "R7 released after reloaded count");

        // R8: zero quanta ends a running hold
        pause_mc(16'd6);
        wait_cyc(2);
        pause_mc(16'd0);
        wait_cyc(2);
        chk(tx_inhibit, 1'b0, "R8 zero quanta release");

        // R9: entry waits for the transmitter to go idle
        tx_busy = 1'b1;
        pause_mc(16'd3);
        wait_cyc(2);
        chk(tx_inhibit, 1'b0, "R9 held off while busy");
        wait_cyc(3);
        chk(tx_inhibit, 1'b0, "R9 still held off");
        tx_busy = 1'b0;
        wait_cyc(1);
        chk(tx_inhibit, 1'b1, "R9 asserts after idle");
        tx_busy = 1'b1;
        wait_cyc(2);
        chk(tx_inhibit, 1'b1, "R9 busy does not release");
        tx_busy = 1'b0;
        clear_hold();

        // R10: load and tick on the same clock, load wins
        pause_mc(16'd10);
        wait_cyc(2);
        pause_mc(16'd3);
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
        @(negedge clk);
        pulse_tick(); pulse_tick();
        chk(tx_inhibit, 1'b1, "R10 two ticks after coincident load");
        pulse_tick();
        chk(tx_inhibit, 1'b0, "R10 released after third tick");

        // R1: reset in the middle of a hold
        pause_mc(16'd5);
        wait_cyc(2);
        rst_n = 1'b0;
        wait_cyc(2);
        chk(tx_inhibit, 1'b0, "R1 reset during hold");
        rst_n = 1'b1;
        wait_cyc(3);
        chk(tx_inhibit, 1'b0, "R1 counter cleared by reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule